// File: doc/BRIEF.md
# B-Tree node key search

This block is the combinational search stage for one node of a B-Tree held in hardware. A node has a fixed number of slots, each carrying a key, a data word and a child link, plus one extra link that is taken when the search runs past every key. Keys are stored in ascending order, with slot 0 holding the smallest.

Given a search key, the unit does three things side by side in one pass of logic. It flags the slot whose key equals the search key and returns that slot's data word. It flags the first slot whose key is larger than the search key. It picks the child link to descend into next. Word selection uses AND-OR trees driven by one-hot masks rather than a priority multiplexer chain, so every output has the same logic depth whichever slot is chosen. A per-slot enable lets a node run with fewer active slots than its capacity.

Top module: `btree_node_search`

## Requirements
- R1: `match_mask` bit i is 1 exactly when slot i is enabled and its key equals `find_key`; bit i refers to slot i, and the field for slot i sits at bits [i*W +: W] of each packed slot bus.
- R2: When any bit of `match_mask` is set, `found` is 1 and `found_data` equals the data word of the matching slot.
- R3: When no enabled key equals `find_key`, `found` is 0 and `found_data` is 0.
- R4: `above_mask` has at most one bit set: the lowest-indexed enabled slot whose key is strictly greater than `find_key`.
- R5: When `above_mask` is non-zero, `next_link` equals the child link of the slot it flags.
- R6: When no enabled key is greater than `find_key`, `above_mask` is 0 and `next_link` equals `top_link`.
- R7: `more_found` is 1 exactly when some enabled slot's key is greater than `find_key`.
- R8: A slot whose `slot_en` bit is 0 never sets a `match_mask` or `above_mask` bit and contributes nothing to `found_data` or `next_link`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| find_key | input | W | Key being searched for |
| slot_en | input | SLOTS | Per-slot enable; bit i enables slot i |
| slot_keys | input | SLOTS*W | Packed keys, ascending by slot index |
| slot_data | input | SLOTS*W | Packed data words |
| slot_links | input | SLOTS*W | Packed child links |
| top_link | input | W | Link followed when no key exceeds the search key |
| match_mask | output | SLOTS | One-hot mask of the exactly matching slot |
| found | output | 1 | An enabled slot matched exactly |
| found_data | output | W | Data of the matching slot, 0 if none |
| above_mask | output | SLOTS | One-hot mask of the first slot with a larger key |
| more_found | output | 1 | Some enabled key is larger than the search key |
| next_link | output | W | Child link to descend into |

## Verification
The bench builds the block with its default of 3 slots and 3-bit fields. With keys that narrow, every search value from 0 to 7 is applied against each node, so each node is probed below its first key, on every key, between keys and past its last key. Random strictly ascending nodes are mixed with partial enable masks, which brings disabled slots in the middle and at the top of the node within reach.

// File: rtl/btree_node_search.sv
module btree_node_search #(
  parameter int SLOTS = 3,
  parameter int W     = 3
) (
  input  logic [W-1:0]       find_key,
  input  logic [SLOTS-1:0]   slot_en,
  input  logic [SLOTS*W-1:0] slot_keys,
  input  logic [SLOTS*W-1:0] slot_data,
  input  logic [SLOTS*W-1:0] slot_links,
  input  logic [W-1:0]       top_link,
  output logic [SLOTS-1:0]   match_mask,
  output logic               found,
  output logic [W-1:0]       found_data,
  output logic [SLOTS-1:0]   above_mask,
  output logic               more_found,
  output logic [W-1:0]       next_link
);

  logic [SLOTS-1:0] bigger;
  logic [SLOTS:0]   seen;
  logic [W-1:0]     data_acc [SLOTS+1];
  logic [W-1:0]     link_acc [SLOTS+1];

  assign seen[0]     = 1'b0;
  assign data_acc[0] = '0;
  assign link_acc[0] = '0;

  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    logic [W-1:0] key;
    assign key           = slot_keys[g*W +: W];
    assign match_mask[g] = slot_en[g] && (key == find_key);
    assign bigger[g]     = slot_en[g] && (key > find_key);
    assign seen[g+1]     = seen[g] | bigger[g];
    assign above_mask[g] = bigger[g] & ~seen[g];
    assign data_acc[g+1] = data_acc[g] | (slot_data[g*W +: W]  & {W{match_mask[g]}});
    assign link_acc[g+1] = link_acc[g] | (slot_links[g*W +: W] & {W{above_mask[g]}});
  end

  assign found      = |match_mask;
  assign found_data = data_acc[SLOTS];
  assign more_found = seen[SLOTS];
  assign next_link  = link_acc[SLOTS] | (top_link & {W{~more_found}});

  always_comb begin
    // R1
    match_onehot_chk: assert ($onehot0(match_mask));
    // R4
    above_onehot_chk: assert ($onehot0(above_mask));
    // R3
    miss_zero_chk: assert (found || found_data == '0);
    // R6
    top_fallback_chk: assert (more_found || next_link == top_link);
    // R7
    more_mask_chk: assert (more_found == (above_mask != '0));
    // R8
    enabled_only_chk: assert (((match_mask | above_mask) & ~slot_en) == '0);
  end

endmodule

// File: tb/btree_node_search_tb.sv
module btree_node_search_tb;
  localparam int SLOTS = 3;
  localparam int W     = 3;

  typedef struct {
    logic [SLOTS-1:0] mm;
    logic             f;
    logic [W-1:0]     fd;
    logic [SLOTS-1:0] am;
    logic             mf;
    logic [W-1:0]     nl;
    string            tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic [W-1:0]       find_key = '0;
  logic [SLOTS-1:0]   slot_en = '0;
  logic [SLOTS*W-1:0] slot_keys = '0, slot_data = '0, slot_links = '0;
  logic [W-1:0]       top_link = '0;
  logic [SLOTS-1:0]   match_mask, above_mask;
  logic               found, more_found;
  logic [W-1:0]       found_data, next_link;

  btree_node_search #(.SLOTS(SLOTS), .W(W)) u_dut (
    .find_key(find_key), .slot_en(slot_en), .slot_keys(slot_keys),
    .slot_data(slot_data), .slot_links(slot_links), .top_link(top_link),
    .match_mask(match_mask), .found(found), .found_data(found_data),
    .above_mask(above_mask), .more_found(more_found), .next_link(next_link));

  logic [W-1:0] nk [SLOTS], nd [SLOTS], nlk [SLOTS];
  exp_t sb [$];
  int applied = 0, errors = 0, cycles = 0;
  bit done = 0;

  task automatic apply(input logic [SLOTS-1:0] en, input logic [W-1:0] s,
                       input logic [W-1:0] top, input string tag);
    exp_t e;
    @(posedge clk);
    #1;
    e.mm = '0; e.f = 0; e.fd = '0; e.am = '0; e.mf = 0; e.nl = top; e.tag = tag;
    for (int i = 0; i < SLOTS; i++) begin
      slot_keys[i*W +: W]  = nk[i];
      slot_data[i*W +: W]  = nd[i];
      slot_links[i*W +: W] = nlk[i];
      if (en[i] && nk[i] == s) begin e.mm[i] = 1; e.f = 1; e.fd = nd[i]; end
    end
    for (int i = 0; i < SLOTS; i++)
      if (en[i] && nk[i] > s && !e.mf) begin e.am[i] = 1; e.mf = 1; e.nl = nlk[i]; end
    slot_en = en; find_key = s; top_link = top;
    sb.push_back(e);
  endtask

  always @(negedge clk) begin
    if (sb.size() != 0) begin
      exp_t e;
      e = sb.pop_front();
      applied++;
      if (match_mask !== e.mm || found !== e.f || found_data !== e.fd ||
          above_mask !== e.am || more_found !== e.mf || next_link !== e.nl) begin
        errors++;
        $display("FAIL %s key=%0d en=%b: got mm=%b f=%b fd=%0d am=%b mf=%b nl=%0d exp mm=%b f=%b fd=%0d am=%b mf=%b nl=%0d",
                 e.tag, find_key, slot_en, match_mask, found, found_data, above_mask,
                 more_found, next_link, e.mm, e.f, e.fd, e.am, e.mf, e.nl);
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      errors++;
      $display("FAIL watchdog expired");
      done = 1;
    end
  end

  initial begin
    nk[0] = 2; nk[1] = 4; nk[2] = 6;
    nd[0] = 1; nd[1] = 3; nd[2] = 5;
    nlk[0] = 1; nlk[1] = 3; nlk[2] = 5;
    // reset: all slots idle, R3 R6 R8
    apply(3'b000, 3'd4, 3'd7, "reset R3 R6 R8");
    repeat (2) @(posedge clk);
    rst_n = 1'b1;
    // example node: below, on, between and above every key
    for (int s = 0; s < 8; s++)
      apply(3'b111, W'(s), 3'd7, "node R1 R2 R3 R4 R5 R6 R7");
    apply(3'b101, 3'd4, 3'd7, "disabled middle R8 R3");
    apply(3'b011, 3'd5, 3'd6, "disabled top R8 R6");
    apply(3'b011, 3'd6, 3'd2, "disabled match R8 R3 R6");
    apply(3'b110, 3'd0, 3'd7, "disabled first R8 R4 R5");
    repeat (200) begin
      logic [SLOTS-1:0] en;
      logic [W-1:0] tp;
      nk[0] = W'($urandom_range(0, 5));
      nk[1] = nk[0] + 1 + W'($urandom_range(0, 5 - nk[0]));
      nk[2] = nk[1] + 1 + W'($urandom_range(0, 6 - nk[1]));
      for (int i = 0; i < SLOTS; i++) begin
        nd[i] = W'($urandom);
        nlk[i] = W'($urandom);
      end
      en = ($urandom_range(0, 3) == 0) ? SLOTS'($urandom) : '1;
      tp = W'($urandom);
      for (int s = 0; s < 8; s++)
        apply(en, W'(s), tp, "random R1 R2 R3 R4 R5 R6 R7 R8");
    end
    repeat (3) @(posedge clk);
    done = 1;
  end

  initial begin
    wait (done);
    @(posedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", applied, errors);
    $finish;
  end

endmodule